// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits behind the 16-bit control port of a tile-based video controller. Every word the CPU writes there is classified in one of two ways. It is either a single-word register update, or one half of a two-word access command. An access command selects the memory that later data-port traffic goes to, sets the direction of that traffic and loads a 16-bit address. It can also ask for a DMA transfer. The address and access-code bits are spread across both words. The block reassembles them, keeps a flag that marks a command half-way through, and clears that flag whenever the CPU touches the data port or reads status.

The block holds a parameterised file of 8-bit registers. Two of them drive its own behaviour: the auto-increment register adds to the address after each data-port access, and the mode register holds a DMA-enable bit. A DMA request that passes the enable check produces a one-cycle pulse. It also sets a busy flag, which shows in the status word until the DMA engine reports completion. The memory arrays and the DMA datapath are not part of this block.

Top module: `vcp_cmd_decoder`

## Requirements
- R1: With no command pending, a control word whose bits 15:14 equal 2'b10 writes bits 7:0 into register number bits 12:8, visible on `regs_flat[8*n +: 8]` one cycle later. An index of NREG (24) or more changes no register.
- R2: With no command pending, any other control word loads address bits 13:0 from word bits 13:0 and access-code bits 1:0 from word bits 15:14, and marks a command as pending.
- R3: With a command pending, the next control word is taken as the second half, whatever its top bits. Address bits 15:14 come from word bits 1:0 and access-code bits 5:2 come from word bits 7:4, and the pending mark is cleared. No register is written.
- R4: The access target is decoded from access-code bits 3:0. `acc_tgt` uses the values 0 none, 1 video RAM, 2 vertical-scroll RAM and 3 color RAM, and `acc_wr` is 1 for writes. The codes are: 0001 video write, 0101 scroll write, 0011 color write, 0000 video read, 0100 scroll read, 1000 color read. Every other code gives target 0 with `acc_wr` 0.
- R5: A data-port access clears the pending mark and adds register 15 to the address, modulo 2^16.
- R6: A status read clears the pending mark and leaves the address unchanged.
- R7: When a second word has bit 7 set and bit 4 of register 1 is 1, `dma_req` pulses high for exactly one cycle after that write. Bit 1 of `status_word` reads 1 from that cycle on. All other status bits are 0.
- R8: When bit 4 of register 1 is 0, bit 7 of a second word causes no `dma_req` pulse and leaves status bit 1 unchanged.
- R9: `dma_done` clears the busy status bit in the following cycle. When a new request is accepted in the same cycle as `dma_done`, the bit stays set.
- R10: When `ctl_wr` is high, `data_acc` and `stat_rd` in that same cycle have no effect.
- R11: After reset, all registers, the address and the pending mark are 0, `dma_req` is 0 and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_word | input | 16 | Control-port write data |
| data_acc | input | 1 | Data-port access strobe (read or write) |
| stat_rd | input | 1 | Status read strobe |
| dma_done | input | 1 | DMA engine completion pulse |
| regs_flat | output | NREG*8 | All registers; register n is at bits 8n+7:8n |
| acc_addr | output | 16 | Current access address |
| acc_tgt | output | 2 | Decoded access target |
| acc_wr | output | 1 | 1 when the access direction is write |
| dma_req | output | 1 | One-cycle DMA start pulse |
| status_word | output | 16 | Status; bit 1 is DMA busy |

## Verification
The bench aims at the cases where the two kinds of words could be confused. One is a second word whose top bits are 10: a decoder that tested the top bits before the pending mark would update a register here and leave the command open. Another is a status read or data access between the two halves: if the mark were not cleared, the next register write would be absorbed as an address. The bench also covers the DMA gate with enable clear, which a careless design would turn into a spurious busy that never ends, and a request accepted in the same cycle as completion, where the wrong precedence drops busy. Out-of-range register indices, wrap of the address increment and simultaneous strobes are covered as well, with a randomised mix compared against the model on every clock.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

  localparam int WORD_W = 16;
  localparam int CODE_W = 6;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_VRAM  = 2'd1,
    TGT_VSRAM = 2'd2,
    TGT_CRAM  = 2'd3
  } tgt_e;

  // map the low access-code nibble to a memory target
  function automatic tgt_e code_target(input logic [3:0] c);
    tgt_e t;
    case (c)
      4'b0001, 4'b0000: t = TGT_VRAM;
      4'b0101, 4'b0100: t = TGT_VSRAM;
      4'b0011, 4'b1000: t = TGT_CRAM;
      default:          t = TGT_NONE;
    endcase
    return t;
  endfunction

  function automatic logic code_is_write(input logic [3:0] c);
    return (c == 4'b0001) || (c == 4'b0101) || (c == 4'b0011);
  endfunction

endpackage

// File: rtl/vcp_regfile.sv
module vcp_regfile #(
  parameter int NREG  = 24,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_val,
  output logic [NREG*8-1:0] regs_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    logic [7:0] d;
    logic       hit;

    always_comb begin
      hit = wr_en && (wr_idx == IDX_W'(g));
      d   = hit ? wr_val : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 8'h00;
      else        q <= d;
    end

    assign regs_flat[g*8 +: 8] = q;
  end

  AST_IDX_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_idx) >= NREG)) |=> $stable(regs_flat)); // R1

  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat)); // R1

endmodule

// File: rtl/vcp_cmd_seq.sv
module vcp_cmd_seq
  import vcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic              data_acc,
  input  logic              stat_rd,
  input  logic [7:0]        incr,
  output logic              reg_wr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [7:0]        reg_val,
  output logic              dma_ask,
  output logic [ADDR_W-1:0] addr,
  output logic [CODE_W-1:0] code
);

  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              is_regword;

  always_comb begin
    pend_d     = pend_q;
    addr_d     = addr_q;
    code_d     = code_q;
    reg_wr     = 1'b0;
    dma_ask    = 1'b0;
    is_regword = (ctl_word[15:14] == 2'b10);
    reg_idx    = ctl_word[12:8];
    reg_val    = ctl_word[7:0];
    if (ctl_wr) begin
      if (pend_q) begin
        addr_d[15:14] = ctl_word[1:0];
        code_d[5:2]   = ctl_word[7:4];
        pend_d        = 1'b0;
        dma_ask       = ctl_word[7];
      end else if (is_regword) begin
        reg_wr = 1'b1;
      end else begin
        addr_d[13:0] = ctl_word[13:0];
        code_d[1:0]  = ctl_word[15:14];
        pend_d       = 1'b1;
      end
    end else if (data_acc) begin
      pend_d = 1'b0;
      addr_d = addr_q + ADDR_W'(incr);
    end else if (stat_rd) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      code_q <= '0;
    end else begin
      pend_q <= pend_d;
      addr_q <= addr_d;
      code_q <= code_d;
    end
  end

  assign addr = addr_q;
  assign code = code_q;

  AST_FIRST_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !pend_q && ctl_word[15:14] != 2'b10) |=> pend_q); // R2

  AST_SECOND_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && pend_q) |-> !reg_wr); // R3

  AST_SECOND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && pend_q) |=> !pend_q); // R3

  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ctl_wr) |=> (!pend_q && addr_q == $past(addr_q) + ADDR_W'($past(incr)))); // R5

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ctl_wr && !data_acc) |=> (!pend_q && $stable(addr_q))); // R6

endmodule

// File: rtl/vcp_dma_ctl.sv
module vcp_dma_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_ask,
  input  logic dma_en,
  input  logic dma_done,
  output logic dma_req,
  output logic busy
);

  logic start;
  logic req_q, req_d;
  logic busy_q, busy_d;

  always_comb begin
    start  = dma_ask && dma_en;
    req_d  = start;
    busy_d = busy_q;
    if (start)         busy_d = 1'b1;
    else if (dma_done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      busy_q <= busy_d;
    end
  end

  assign dma_req = req_q;
  assign busy    = busy_q;

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(dma_en)); // R8

  AST_BUSY_RISE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> dma_req); // R7

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !$past(start)) |-> 1'b0); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done && !start) |=> !busy_q); // R9

endmodule

// File: rtl/vcp_cmd_decoder.sv
module vcp_cmd_decoder
  import vcp_pkg::*;
#(
  parameter int NREG    = 24,
  parameter int INC_REG = 15,
  parameter int EN_REG  = 1,
  parameter int EN_BIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [15:0]       ctl_word,
  input  logic              data_acc,
  input  logic              stat_rd,
  input  logic              dma_done,
  output logic [NREG*8-1:0] regs_flat,
  output logic [15:0]       acc_addr,
  output logic [1:0]        acc_tgt,
  output logic              acc_wr,
  output logic              dma_req,
  output logic [15:0]       status_word
);

  localparam int BUSY_BIT = 1;

  logic              reg_wr;
  logic [IDX_W-1:0]  reg_idx;
  logic [7:0]        reg_val;
  logic              dma_ask;
  logic              dma_busy;
  logic [CODE_W-1:0] code;
  logic [7:0]        incr;
  logic              dma_en;

  assign incr   = regs_flat[INC_REG*8 +: 8];
  assign dma_en = regs_flat[EN_REG*8 + EN_BIT];

  vcp_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .wr_idx    (reg_idx),
    .wr_val    (reg_val),
    .regs_flat (regs_flat)
  );

  vcp_cmd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_word (ctl_word),
    .data_acc (data_acc),
    .stat_rd  (stat_rd),
    .incr     (incr),
    .reg_wr   (reg_wr),
    .reg_idx  (reg_idx),
    .reg_val  (reg_val),
    .dma_ask  (dma_ask),
    .addr     (acc_addr),
    .code     (code)
  );

  vcp_dma_ctl u_dma (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_ask  (dma_ask),
    .dma_en   (dma_en),
    .dma_done (dma_done),
    .dma_req  (dma_req),
    .busy     (dma_busy)
  );

  always_comb begin
    acc_tgt               = code_target(code[3:0]);
    acc_wr                = code_is_write(code[3:0]);
    status_word           = '0;
    status_word[BUSY_BIT] = dma_busy;
  end

  AST_NONE_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_tgt == 2'd0) |-> !acc_wr); // R4

  AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_word) <= 1); // R7

endmodule

// File: tb/sim_vcp_cmd_decoder.sv
`timescale 1ns/1ps
module sim_vcp_cmd_decoder;

  localparam int NREG = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ctl_wr, data_acc, stat_rd, dma_done;
  logic [15:0]       ctl_word;
  logic [NREG*8-1:0] regs_flat;
  logic [15:0]       acc_addr, status_word;
  logic [1:0]        acc_tgt;
  logic              acc_wr, dma_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int         m_regs [NREG];
  logic [15:0] m_addr;
  logic [5:0]  m_code;
  bit          m_pend, m_busy, m_req;

  always #2 clk = ~clk;

  vcp_cmd_decoder #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
    .data_acc(data_acc), .stat_rd(stat_rd), .dma_done(dma_done),
    .regs_flat(regs_flat), .acc_addr(acc_addr), .acc_tgt(acc_tgt),
    .acc_wr(acc_wr), .dma_req(dma_req), .status_word(status_word)
  );

  function automatic logic [2:0] exp_access(input logic [5:0] c);
    logic [2:0] r;
    case (c[3:0])
      4'b0001: r = {2'd1, 1'b1};
      4'b0101: r = {2'd2, 1'b1};
      4'b0011: r = {2'd3, 1'b1};
      4'b0000: r = {2'd1, 1'b0};
      4'b0100: r = {2'd2, 1'b0};
      4'b1000: r = {2'd3, 1'b0};
      default: r = 3'b000;
    endcase
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) m_regs[i] = 0;
    m_addr = 0; m_code = 0; m_pend = 0; m_busy = 0; m_req = 0;
  endtask

  task automatic model_step(input bit c, input logic [15:0] w, input bit d,
                            input bit s, input bit dn);
    bit en;
    bit start;
    int inc;
    en    = m_regs[1][4];
    inc   = m_regs[15];
    start = 0;
    if (c) begin
      if (m_pend) begin
        m_addr[15:14] = w[1:0];
        m_code[5:2]   = w[7:4];
        m_pend        = 0;
        start         = w[7] && en;
      end else if (w[15:14] == 2'b10) begin
        if (int'(w[12:8]) < NREG) m_regs[w[12:8]] = w[7:0];
      end else begin
        m_addr[13:0] = w[13:0];
        m_code[1:0]  = w[15:14];
        m_pend       = 1;
      end
    end else if (d) begin
      m_pend = 0;
      m_addr = 16'((int'(m_addr) + inc) % 65536);
    end else if (s) begin
      m_pend = 0;
    end
    m_req = start;
    if (start) m_busy = 1;
    else if (dn) m_busy = 0;
  endtask

  task automatic compare(input string tag);
    logic [2:0] ea;
    logic [15:0] es;
    bit bad;
    bad = 0;
    checks++;
    for (int i = 0; i < NREG; i++) begin
      if (regs_flat[i*8 +: 8] !== 8'(m_regs[i])) begin
        $display("FAIL %s reg%0d actual %h expected %h", tag, i, regs_flat[i*8 +: 8], 8'(m_regs[i]));
        bad = 1;
      end
    end
    if (acc_addr !== m_addr) begin
      $display("FAIL %s addr actual %h expected %h", tag, acc_addr, m_addr); bad = 1;
    end
    ea = exp_access(m_code);
    if ({acc_tgt, acc_wr} !== ea) begin
      $display("FAIL %s access actual %b expected %b", tag, {acc_tgt, acc_wr}, ea); bad = 1;
    end
    if (dma_req !== m_req) begin
      $display("FAIL %s dma_req actual %b expected %b", tag, dma_req, m_req); bad = 1;
    end
    es = {14'd0, m_busy, 1'b0};
    if (status_word !== es) begin
      $display("FAIL %s status actual %h expected %h", tag, status_word, es); bad = 1;
    end
    if (bad) errors++;
  endtask

  task automatic step(input string tag, input bit c, input logic [15:0] w,
                      input bit d, input bit s, input bit dn);
    @(negedge clk);
    ctl_wr = c; ctl_word = w; data_acc = d; stat_rd = s; dma_done = dn;
    @(posedge clk);
    model_step(c, w, d, s, dn);
    #1;
    compare(tag);
  endtask

  task automatic cw(input string tag, input logic [15:0] w);
    step(tag, 1, w, 0, 0, 0);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 16'h0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ctl_wr = 0; ctl_word = 0; data_acc = 0; stat_rd = 0; dma_done = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    compare("R11");

    // register writes, including out-of-range index
    cw("R1", 16'h8F02);
    cw("R1", 16'h8110);
    cw("R1", 16'h97AB);
    cw("R1", 16'h9955);
    cw("R1", 16'h9F66);

    // two-word video write command
    cw("R2", 16'h5234);
    idle("R2");
    cw("R3", 16'h0002);
    idle("R4");

    // data accesses advance by register 15
    step("R5", 0, 0, 1, 0, 0);
    step("R5", 0, 0, 1, 0, 0);
    step("R5", 0, 0, 1, 0, 0);

    // second word with top bits 10 must not write a register
    cw("R3", 16'h4000);
    cw("R3", 16'h8010);
    idle("R3");

    // target decode sweep
    cw("R4", 16'hC000); cw("R4", 16'h0000);
    cw("R4", 16'h0000); cw("R4", 16'h0020);
    cw("R4", 16'h0000); cw("R4", 16'h0010);
    cw("R4", 16'h0000); cw("R4", 16'h0000);
    cw("R4", 16'h4000); cw("R4", 16'h0020);
    cw("R4", 16'h4000); cw("R4", 16'h0040);

    // status read between halves
    cw("R6", 16'h4100);
    step("R6", 0, 0, 0, 1, 0);
    cw("R6", 16'h8277);
    // data access between halves
    cw("R5", 16'h4100);
    step("R5", 0, 0, 1, 0, 0);
    cw("R5", 16'h8388);

    // address wrap with large increment
    cw("R5", 16'h8FFF);
    cw("R5", 16'h7FFF); cw("R5", 16'h0003);
    step("R5", 0, 0, 1, 0, 0);
    step("R5", 0, 0, 1, 0, 0);
    cw("R5", 16'h8F02);

    // DMA accepted
    cw("R7", 16'h4000);
    cw("R7", 16'h0080);
    idle("R7");
    idle("R7");
    step("R9", 0, 0, 0, 0, 1);
    idle("R9");

    // DMA gated off
    cw("R8", 16'h8100);
    cw("R8", 16'h4000);
    cw("R8", 16'h0080);
    idle("R8");

    // request in same cycle as completion
    cw("R9", 16'h8110);
    cw("R9", 16'h4000);
    step("R9", 1, 16'h0080, 0, 0, 1);
    idle("R9");
    step("R9", 0, 0, 0, 0, 1);

    // simultaneous strobes
    step("R10", 1, 16'h4444, 1, 1, 0);
    step("R10", 1, 16'h0001, 1, 0, 0);
    step("R10", 1, 16'h8511, 0, 1, 0);

    // randomised mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (($urandom % 4) == 0) w[15:13] = 3'b100;
      step("RND", ($urandom % 3) == 0, w, ($urandom % 4) == 0,
           ($urandom % 5) == 0, ($urandom % 6) == 0);
    end
    idle("RND");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule